// File: doc/BRIEF.md
# Interrupt Priority Level Evaluator

The block inspects two groups of pending interrupts every clock. The first group is a software request vector and the second is a vector of external interrupt lines. From these it works out a single pending priority level and compares it with the current processor priority level. When the pending level is strictly higher, the block raises a one-clock trap request. In the same clock it captures two things: a summary of every pending bit, and the level that caused the trap.

The two groups map to levels differently. A software bit at index i in the window 18..4 gives level i−3, so the levels run from 1 to 15. An external bit in the window EXT_LO..EXT_HI (default 20..31) gives a level equal to its own index. Whenever any external bit is pending, the external level replaces the software level.

A separate asynchronous-trap request port is not serviced. If it is nonzero, the block flags an error instead. The reset is asynchronous and active low, and the block releases it internally through a two-stage synchronizer.

Top module: `irq_level_eval`

## Requirements
- R1: A software bit at index i, with 4 ≤ i ≤ 18, gives level i−3, and the highest such bit sets the software level. Software bits outside 18..4 are ignored.
- R2: An external bit at index i, with 20 ≤ i ≤ 31, gives level i, and the highest such bit sets the external level. External bits below 20 are ignored.
- R3: When any in-range external bit is pending, the pending level is the external level, whatever software bits are also set.
- R4: The summary is the OR of all in-range software and external pending bits, each kept at its own bit position.
- R5: A trap is issued only when the pending level is nonzero and strictly greater than cur_ipl. A level equal to cur_ipl does not trap.
- R6: Inputs are sampled on one clock edge. On the next edge trap_o rises, summary_o takes the summary vector and id_o takes the pending level.
- R7: In any cycle without a trap, summary_o and id_o keep their previous values.
- R8: trap_o is never high in two consecutive cycles. A request that is still pending after a trap issues another trap two cycles after the first one.
- R9: A nonzero async_req sets async_err_o on the next edge. async_err_o clears one edge after async_req returns to zero.
- R10: While reset is held, and after reset is released, every output reads zero until a trap occurs or an async request arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_req | input | 32 | Software interrupt request vector; bits 18..4 are used |
| ext_irq | input | 32 | External interrupt lines; bits EXT_LO..EXT_HI are used |
| cur_ipl | input | 5 | Current interrupt priority level |
| async_req | input | 4 | Asynchronous trap request; unsupported |
| trap_o | output | 1 | One-clock trap request |
| summary_o | output | 32 | Captured pending-bit summary |
| id_o | output | 5 | Captured interrupt level |
| async_err_o | output | 1 | Unsupported asynchronous request flag |

## Verification
Software and external requests can both be pending in the same cycle. Several vectors drive both groups at once, with the software level set above, below or equal to the point where the external level decides the outcome. Each vector is judged on id_o, which must show the external index, and on summary_o, which must keep the bits of both groups. A request is also held across several cycles to check that it cannot trap in two consecutive cycles, while the cycle after each trap is still evaluated.

// File: rtl/irq_eval_pkg.sv
`timescale 1ns/1ps
package irq_eval_pkg;
  localparam int unsigned VEC_W   = 32;
  localparam int unsigned LVL_W   = 5;
  localparam int unsigned ASYNC_W = 4;
  localparam int unsigned SW_LO   = 4;
  localparam int unsigned SW_HI   = 18;
  localparam int unsigned EXT_LO  = 20;
  localparam int unsigned EXT_HI  = 31;

  typedef enum logic {MAP_RELATIVE = 1'b0, MAP_DIRECT = 1'b1} lvl_map_e;
endpackage

// File: rtl/irq_hi_scan.sv
`timescale 1ns/1ps
// Scans the window LO..HI of a request vector. It returns the in-window bits
// and the level of the highest set bit. The level is either the index itself
// or the index taken relative to LO, counting from 1.
module irq_hi_scan
  import irq_eval_pkg::*;
#(
  parameter int unsigned W     = 32,
  parameter int unsigned LW    = 5,
  parameter int unsigned LO    = 4,
  parameter int unsigned HI    = 18,
  parameter lvl_map_e    MAP   = MAP_RELATIVE
) (
  input  logic [W-1:0]  vec,
  output logic [W-1:0]  field,
  output logic          any,
  output logic [LW-1:0] lvl
);
  localparam int unsigned SPAN = HI - LO + 1;

  for (genvar k = 0; k < W; k++) begin : g_win
    if (k >= LO && k <= HI) begin : g_in
      assign field[k] = vec[k];
    end else begin : g_out
      assign field[k] = 1'b0;
    end
  end

  assign any = |field;

  always_comb begin
    lvl = '0;
    for (int i = LO; i < LO + SPAN; i++) begin
      if (field[i]) begin
        if (MAP == MAP_DIRECT) lvl = LW'(i);
        else                   lvl = LW'(i - LO + 1);
      end
    end
  end
endmodule

// File: rtl/irq_level_merge.sv
`timescale 1ns/1ps
// Merges the two groups (external overrides software) and decides whether a
// trap is warranted against the current priority level.
module irq_level_merge #(
  parameter int unsigned W  = 32,
  parameter int unsigned LW = 5
) (
  input  logic [W-1:0]  sw_field,
  input  logic          sw_any,
  input  logic [LW-1:0] sw_lvl,
  input  logic [W-1:0]  ext_field,
  input  logic          ext_any,
  input  logic [LW-1:0] ext_lvl,
  input  logic [LW-1:0] cur_ipl,
  output logic [W-1:0]  summary,
  output logic [LW-1:0] level,
  output logic          fire
);
  always_comb begin
    summary = sw_field | ext_field;
    if (ext_any)     level = ext_lvl;
    else if (sw_any) level = sw_lvl;
    else             level = '0;
    fire = (level != '0) && (level > cur_ipl);
  end
endmodule

// File: rtl/irq_level_eval.sv
`timescale 1ns/1ps
module irq_level_eval
  import irq_eval_pkg::*;
#(
  parameter int unsigned VW     = VEC_W,
  parameter int unsigned LW     = LVL_W,
  parameter int unsigned AW     = ASYNC_W,
  parameter int unsigned S_LO   = SW_LO,
  parameter int unsigned S_HI   = SW_HI,
  parameter int unsigned E_LO   = EXT_LO,
  parameter int unsigned E_HI   = EXT_HI
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [VW-1:0] sw_req,
  input  logic [VW-1:0] ext_irq,
  input  logic [LW-1:0] cur_ipl,
  input  logic [AW-1:0] async_req,
  output logic          trap_o,
  output logic [VW-1:0] summary_o,
  output logic [LW-1:0] id_o,
  output logic          async_err_o
);
  // reset: asynchronous assert, synchronous release
  logic rst_q1, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_q1     <= 1'b1;
      rst_sync_n <= rst_q1;
    end
  end

  logic [VW-1:0] sw_field, ext_field, sum_c;
  logic          sw_any, ext_any, fire;
  logic [LW-1:0] sw_lvl, ext_lvl, lvl_c;

  irq_hi_scan #(.W(VW), .LW(LW), .LO(S_LO), .HI(S_HI), .MAP(MAP_RELATIVE)) u_sw_scan (
    .vec(sw_req), .field(sw_field), .any(sw_any), .lvl(sw_lvl)
  );

  irq_hi_scan #(.W(VW), .LW(LW), .LO(E_LO), .HI(E_HI), .MAP(MAP_DIRECT)) u_ext_scan (
    .vec(ext_irq), .field(ext_field), .any(ext_any), .lvl(ext_lvl)
  );

  irq_level_merge #(.W(VW), .LW(LW)) u_merge (
    .sw_field(sw_field), .sw_any(sw_any), .sw_lvl(sw_lvl),
    .ext_field(ext_field), .ext_any(ext_any), .ext_lvl(ext_lvl),
    .cur_ipl(cur_ipl), .summary(sum_c), .level(lvl_c), .fire(fire)
  );

  // next state
  logic          take;
  logic          trap_d, err_d;
  logic [VW-1:0] sum_d;
  logic [LW-1:0] id_d;

  always_comb begin
    take   = fire && !trap_o;        // single-cycle trap pulse
    trap_d = take;
    sum_d  = summary_o;
    id_d   = id_o;
    if (take) begin
      sum_d = sum_c;
      id_d  = lvl_c;
    end
    err_d = |async_req;
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      trap_o      <= 1'b0;
      summary_o   <= '0;
      id_o        <= '0;
      async_err_o <= 1'b0;
    end else begin
      trap_o      <= trap_d;
      async_err_o <= err_d;
      if (take) begin
        summary_o <= sum_d;
        id_o      <= id_d;
      end
    end
  end

  // assertions
  p_trap_single_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    trap_o |=> !trap_o);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !trap_o |-> ($stable(summary_o) && $stable(id_o)));

  p_above_ipl_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    trap_o |-> (id_o != '0) && (id_o > $past(cur_ipl)));

  p_async_flag_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|async_req) |=> async_err_o);

  p_sum_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    trap_o |-> (summary_o != '0));
endmodule

// File: tb/irq_level_eval_bench.sv
`timescale 1ns/1ps
module irq_level_eval_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] sw_req, ext_irq;
  logic [4:0]  cur_ipl;
  logic [3:0]  async_req;
  logic        trap_o, async_err_o;
  logic [31:0] summary_o;
  logic [4:0]  id_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  irq_level_eval u_irq_level_eval (
    .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .ext_irq(ext_irq),
    .cur_ipl(cur_ipl), .async_req(async_req), .trap_o(trap_o),
    .summary_o(summary_o), .id_o(id_o), .async_err_o(async_err_o)
  );

  // {sw, ext, ipl, trap, id, summary}
  localparam int NV = 13;
  localparam logic [106:0] VTAB [NV] = '{
    {32'h0000_0010, 32'h0000_0000, 5'd0,  1'b1, 5'd1,  32'h0000_0010}, // R1 lowest sw
    {32'h0004_0010, 32'h0000_0000, 5'd0,  1'b1, 5'd15, 32'h0004_0010}, // R1 highest sw wins
    {32'h0000_000F, 32'h0000_0000, 5'd0,  1'b0, 5'd15, 32'h0004_0010}, // R1 low bits ignored, R7
    {32'h0008_0000, 32'h000F_FFFF, 5'd0,  1'b0, 5'd15, 32'h0004_0010}, // R2 out of window, R7
    {32'h0000_0000, 32'h0010_0000, 5'd0,  1'b1, 5'd20, 32'h0010_0000}, // R2 lowest ext
    {32'h0004_0000, 32'h8000_0000, 5'd0,  1'b1, 5'd31, 32'h8004_0000}, // R3 R4
    {32'h0000_0100, 32'h0000_0000, 5'd5,  1'b0, 5'd31, 32'h8004_0000}, // R5 equal level
    {32'h0000_0100, 32'h0000_0000, 5'd4,  1'b1, 5'd5,  32'h0000_0100}, // R5 one above
    {32'h0007_FFF0, 32'h0030_0000, 5'd20, 1'b1, 5'd21, 32'h0037_FFF0}, // R3 R4 R6
    {32'h0000_0000, 32'h0200_0000, 5'd31, 1'b0, 5'd21, 32'h0037_FFF0}, // R5 R7
    {32'h0000_0020, 32'h0040_0000, 5'd21, 1'b1, 5'd22, 32'h0040_0020}, // R3 R6
    {32'h0000_0000, 32'h0000_0000, 5'd0,  1'b0, 5'd22, 32'h0040_0020}, // R7 idle
    {32'hFFFF_FFFF, 32'h0000_0000, 5'd14, 1'b1, 5'd15, 32'h0007_FFF0}  // R1 mask R4
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] s, input logic [31:0] e, input logic [4:0] l);
    sw_req = s; ext_irq = e; cur_ipl = l;
  endtask

  initial begin
    rst_n = 1'b0; drive(32'h0, 32'h0, 5'd0); async_req = 4'h0;
    repeat (3) @(negedge clk);
    check("R10 trap in reset", {31'b0, trap_o}, 32'h0);
    check("R10 summary in reset", summary_o, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 id after reset", {27'b0, id_o}, 32'h0);
    check("R10 err after reset", {31'b0, async_err_o}, 32'h0);

    for (int v = 0; v < NV; v++) begin
      drive(VTAB[v][106:75], VTAB[v][74:43], VTAB[v][42:38]);
      @(negedge clk);
      check($sformatf("R6 trap vec%0d", v), {31'b0, trap_o}, {31'b0, VTAB[v][37]});
      check($sformatf("R6 id vec%0d", v), {27'b0, id_o}, {27'b0, VTAB[v][36:32]});
      check($sformatf("R4 summary vec%0d", v), summary_o, VTAB[v][31:0]);
      drive(32'h0, 32'h0, 5'd31);
      @(negedge clk);
    end

    // R8: persistent request pulses 1,0,1,0
    drive(32'h0000_0010, 32'h0, 5'd0);
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      check($sformatf("R8 pulse cycle%0d", c), {31'b0, trap_o}, (c % 2 == 0) ? 32'h1 : 32'h0);
    end
    drive(32'h0, 32'h0, 5'd0);
    @(negedge clk);

    // R9: async request flag
    async_req = 4'h2;
    @(negedge clk);
    check("R9 err set", {31'b0, async_err_o}, 32'h1);
    async_req = 4'h0;
    @(negedge clk);
    check("R9 err clear", {31'b0, async_err_o}, 32'h0);

    // R10: reset mid-run clears captured state
    rst_n = 1'b0;
    @(negedge clk);
    check("R10 id cleared", {27'b0, id_o}, 32'h0);
    check("R10 summary cleared", summary_o, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule